// File: doc/BRIEF.md
# Transport Stream Sync Lock Detector

This block recovers packet framing from a raw transport stream. Bytes arrive with a valid strobe, either one whole byte per strobe (parallel) or one bit per strobe (serial, most significant bit first). In serial mode a start-of-packet input marks the first bit of a packet and fixes the byte alignment. A configuration bit picks whether the inputs are sampled on the rising or the falling clock edge.

Every assembled byte is passed on unchanged. A state machine watches for the sync token 0x47 at a fixed spacing of `PKT_LEN` bytes (188 by default). There are four states. **HUNT** looks for any token byte. **VERIFY** counts consecutive tokens at the expected spacing. **LOCK** is the framed state. **SLIP** is still framed but has recent misses. The transitions are:

- HUNT→VERIFY: a token byte is seen.
- VERIFY→LOCK: `LOCK_HITS` consecutive tokens have been seen (9 by default).
- VERIFY→HUNT: the expected slot holds a wrong byte.
- LOCK→SLIP: the first wrong byte at a slot.
- SLIP→LOCK: a good token at a slot.
- SLIP→HUNT: `LOSS_MISSES` consecutive misses (9 by default).

While framed, the block marks the first and the last byte of every packet.

Top module: `ts_sync_lock`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid`, `out_sop`, `out_eop` and `out_locked` are 0 until a byte is accepted.
- R2: With `cfg_serial`=0, each cycle with `in_valid`=1 accepts `in_data` as one byte. Every accepted byte appears once on `out_data` with `out_valid`=1, in order and unchanged.
- R3: Cycles with `in_valid`=0 produce no output byte and do not advance the packet position, whatever is on `in_data`.
- R4: In HUNT, a byte equal to 0x47 starts a candidate framing. The byte at position 0 of a packet is the sync slot, and positions run 0 to `PKT_LEN`-1. `out_locked` rises together with the output of the `LOCK_HITS`-th consecutive 0x47 found at `PKT_LEN`-byte spacing, and that byte carries `out_sop`=1.
- R5: In VERIFY, a non-0x47 byte at the sync slot returns to HUNT and clears the hit count. Other 0x47 bytes seen during VERIFY start no new candidate.
- R6: `out_sop` is 1 only while framed, and only on the byte at the sync slot. `out_eop` is 1 only while framed, and only on the byte at position `PKT_LEN`-1.
- R7: While framed, a wrong byte at the sync slot neither drops lock nor moves the framing, and that byte still carries `out_sop`. A following good 0x47 at the slot clears the miss count.
- R8: `out_locked` falls together with the output of the `LOSS_MISSES`-th consecutive wrong byte at the sync slot, and that byte carries no `out_sop`.
- R9: With `cfg_serial`=1, each valid cycle shifts in one bit from `in_bit`. The first bit becomes bit 7 of the byte, and a byte is emitted after 8 bits.
- R10: In serial mode, a valid bit with `in_sop`=1 becomes bit 7 of a new byte, and any partly assembled bits are discarded.
- R11: With `cfg_inv_edge`=0, the inputs are sampled at the rising clock edge. With `cfg_inv_edge`=1, they are sampled at the falling edge. Either way the outputs change on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_serial | input | 1 | 1: serial bit input, 0: parallel byte input |
| cfg_inv_edge | input | 1 | 1: sample inputs on the falling edge |
| in_valid | input | 1 | Input strobe |
| in_data | input | 8 | Parallel byte |
| in_bit | input | 1 | Serial bit |
| in_sop | input | 1 | Serial packet start, marks the first bit |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a framed packet |
| out_eop | output | 1 | Last byte of a framed packet |
| out_locked | output | 1 | Framing is held (LOCK or SLIP) |

## Verification
The assertions assume that `PKT_LEN` is at least 2. They also assume that the configuration inputs stay constant between resets, since a mode change in mid-stream would break the output relations they check. The bench therefore changes `cfg_serial` and `cfg_inv_edge` only while reset is held. In falling-edge mode it holds the data valid only around the falling edge, and payload bytes never equal the token unless a scenario places one on purpose.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2,
        ST_SLIP   = 2'd3
    } sync_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              sbit;
        logic              sop;
    } cap_word_t;

endpackage

// File: rtl/ts_sync_capture.sv
module ts_sync_capture
    import ts_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inv_edge,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_bit,
    input  logic              in_sop,
    output cap_word_t         cap
);

    cap_word_t fall_q;
    cap_word_t direct_w;

    assign direct_w = '{valid: in_valid, data: in_data, sbit: in_bit, sop: in_sop};

    // falling-edge sampler for the inverted clock option
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= direct_w;
        end
    end

    // retime into the rising-edge domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap <= '0;
        end else begin
            cap <= cfg_inv_edge ? fall_q : direct_w;
        end
    end

endmodule

// File: rtl/ts_sync_deser.sv
module ts_sync_deser
    import ts_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_serial,
    input  cap_word_t         cap,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [BYTE_W-1:0] shift_q, shift_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              emit;

    always_comb begin
        shift_n = shift_q;
        cnt_n   = cnt_q;
        emit    = 1'b0;
        if (cap.valid && cfg_serial) begin
            if (cap.sop) begin
                shift_n = {{(BYTE_W-1){1'b0}}, cap.sbit};
                cnt_n   = CNT_W'(1);
            end else begin
                shift_n = {shift_q[BYTE_W-2:0], cap.sbit};
                cnt_n   = cnt_q + CNT_W'(1);
            end
            if (cnt_n == FULL) begin
                emit  = 1'b1;
                cnt_n = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q    <= '0;
            cnt_q      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            shift_q <= shift_n;
            cnt_q   <= cnt_n;
            if (cfg_serial) begin
                byte_valid <= emit;
                if (emit) byte_data <= shift_n;
            end else begin
                byte_valid <= cap.valid;
                if (cap.valid) byte_data <= cap.data;
            end
        end
    end

endmodule

// File: rtl/ts_sync_core.sv
module ts_sync_core
    import ts_sync_pkg::*;
#(
    parameter int                PKT_LEN     = 188,
    parameter int                LOCK_HITS   = 9,
    parameter int                LOSS_MISSES = 9,
    parameter logic [BYTE_W-1:0] SYNC_BYTE   = 8'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_locked
);

    localparam int POS_W  = (PKT_LEN > 2) ? $clog2(PKT_LEN) : 1;
    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(LOSS_MISSES + 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(PKT_LEN - 1);
    localparam logic [HIT_W-1:0]  HIT_GOAL  = HIT_W'(LOCK_HITS);
    localparam logic [MISS_W-1:0] MISS_GOAL = MISS_W'(LOSS_MISSES);

    sync_state_e       st_q, st_n;
    logic [POS_W-1:0]  pos_q, pos_n, pos_step;
    logic [HIT_W-1:0]  hits_q, hits_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    logic              is_sync, at_slot, slot_now, framed_now, framed_next;

    assign is_sync     = (byte_data == SYNC_BYTE);
    assign at_slot     = (pos_q == '0);
    assign pos_step    = (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
    assign framed_now  = (st_q == ST_LOCK) || (st_q == ST_SLIP);
    assign framed_next = (st_n == ST_LOCK) || (st_n == ST_SLIP);
    assign slot_now    = (st_q == ST_HUNT) ? is_sync : at_slot;

    // next-state logic
    always_comb begin
        st_n   = st_q;
        pos_n  = pos_q;
        hits_n = hits_q;
        miss_n = miss_q;
        if (byte_valid) begin
            pos_n = pos_step;
            unique case (st_q)
                ST_HUNT: begin
                    pos_n = POS_W'(1);
                    if (is_sync) begin
                        hits_n = HIT_W'(1);
                        st_n   = (HIT_GOAL == HIT_W'(1)) ? ST_LOCK : ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (at_slot) begin
                        if (is_sync) begin
                            hits_n = hits_q + HIT_W'(1);
                            if (hits_n == HIT_GOAL) st_n = ST_LOCK;
                        end else begin
                            st_n = ST_HUNT;
                        end
                    end
                end
                ST_LOCK: begin
                    if (at_slot && !is_sync) begin
                        miss_n = MISS_W'(1);
                        st_n   = (MISS_GOAL == MISS_W'(1)) ? ST_HUNT : ST_SLIP;
                    end
                end
                ST_SLIP: begin
                    if (at_slot) begin
                        if (is_sync) begin
                            miss_n = '0;
                            st_n   = ST_LOCK;
                        end else begin
                            miss_n = miss_q + MISS_W'(1);
                            if (miss_n == MISS_GOAL) st_n = ST_HUNT;
                        end
                    end
                end
                default: st_n = ST_HUNT;
            endcase
            if (st_n == ST_HUNT) begin
                hits_n = '0;
                miss_n = '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            pos_q  <= '0;
            hits_q <= '0;
            miss_q <= '0;
        end else begin
            st_q   <= st_n;
            pos_q  <= pos_n;
            hits_q <= hits_n;
            miss_q <= miss_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= byte_valid;
            if (byte_valid) out_data <= byte_data;
            out_sop <= byte_valid && slot_now && framed_next;
            out_eop <= byte_valid && framed_now && (pos_q == LAST_POS);
        end
    end

    assign out_locked = framed_now;

endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock
    import ts_sync_pkg::*;
#(
    parameter int          PKT_LEN     = 188,
    parameter int          LOCK_HITS   = 9,
    parameter int          LOSS_MISSES = 9,
    parameter logic [7:0]  SYNC_BYTE   = 8'h47
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_serial,
    input  logic       cfg_inv_edge,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_bit,
    input  logic       in_sop,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sop,
    output logic       out_eop,
    output logic       out_locked
);

    cap_word_t         cap;
    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;

    ts_sync_capture u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_inv_edge (cfg_inv_edge),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_bit       (in_bit),
        .in_sop       (in_sop),
        .cap          (cap)
    );

    ts_sync_deser u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_serial (cfg_serial),
        .cap        (cap),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    ts_sync_core #(
        .PKT_LEN     (PKT_LEN),
        .LOCK_HITS   (LOCK_HITS),
        .LOSS_MISSES (LOSS_MISSES),
        .SYNC_BYTE   (SYNC_BYTE)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_locked (out_locked)
    );

endmodule

// File: rtl/ts_sync_lock_chk.sv
module ts_sync_lock_chk #(
    parameter logic [7:0] SYNC_BYTE = 8'h47
) (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sop,
    input logic       out_eop,
    input logic       out_locked
);

    p_marks_need_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_locked);

    p_marks_on_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    p_sop_eop_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_sop && out_eop));

    p_lock_on_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_locked) |-> (out_valid && out_sop && out_data == SYNC_BYTE));

    p_loss_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_locked) |-> (out_valid && !out_sop && out_data != SYNC_BYTE));

    p_idle_no_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_locked));

endmodule

bind ts_sync_lock ts_sync_lock_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_locked (out_locked)
);

// File: tb/ts_sync_lock_bench.sv
`timescale 1ns/1ps
module ts_sync_lock_bench;

    localparam int PL    = 188;
    localparam int DEPTH = 4096;
    localparam int LOCK_AT = 8 * PL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_inv_edge = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_bit = 1'b0;
    logic       in_sop = 1'b0;
    logic       out_valid, out_sop, out_eop, out_locked;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] exp_data [DEPTH];
    logic [7:0] got_data [DEPTH];
    bit         got_sop  [DEPTH];
    bit         got_eop  [DEPTH];
    bit         got_lock [DEPTH];
    int in_n = 0;
    int out_n = 0;

    always #4 clk = ~clk;

    ts_sync_lock u_ts_sync_lock (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_inv_edge(cfg_inv_edge),
        .in_valid(in_valid), .in_data(in_data), .in_bit(in_bit), .in_sop(in_sop),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_locked(out_locked)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            out_n = 0;
        end else if (out_valid) begin
            if (out_n < DEPTH) begin
                got_data[out_n] = out_data;
                got_sop[out_n]  = out_sop;
                got_eop[out_n]  = out_eop;
                got_lock[out_n] = out_locked;
            end
            out_n = out_n + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic logic [7:0] payload(input int idx);
        logic [7:0] v;
        v = 8'((idx * 7 + 3) & 255);
        if (v == 8'h47) v = 8'h48;
        return v;
    endfunction

    function automatic logic [7:0] pkt_byte(input int pkt, input int off, input bit good);
        if (off == 0) return good ? 8'h47 : 8'h00;
        return payload(pkt * PL + off);
    endfunction

    task automatic begin_run(input bit ser, input bit inv);
        @(posedge clk); #1;
        rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0;
        cfg_serial = ser; cfg_inv_edge = inv;
        in_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic put_par(input logic [7:0] b, input bit gap);
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = b;
        exp_data[in_n] = b; in_n = in_n + 1;
        if (gap) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_data = 8'h47;
        end
    endtask

    task automatic put_inv(input logic [7:0] b);
        @(posedge clk); #2;
        in_valid = 1'b1; in_data = b;
        #4 in_data = ~b;
        exp_data[in_n] = b; in_n = in_n + 1;
    endtask

    task automatic put_ser(input logic [7:0] b, input bit first);
        for (int i = 7; i >= 0; i--) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_bit = b[i];
            in_sop = first && (i == 7);
        end
        exp_data[in_n] = b; in_n = in_n + 1;
    endtask

    task automatic drain;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic check_data(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < in_n && i < DEPTH; i++)
            if (got_data[i] !== exp_data[i]) bad = bad + 1;
        check(out_n == in_n, {tag, " byte count"}, out_n, in_n);
        check(bad == 0, {tag, " byte values"}, bad, 0);
    endtask

    task automatic check_lock_at(input int at, input string tag);
        int early;
        early = 0;
        for (int i = 0; i < at; i++) if (got_sop[i] || got_eop[i]) early = early + 1;
        check(got_lock[at-1] == 1'b0, {tag, " unlocked before last hit"}, got_lock[at-1], 0);
        check(got_lock[at] == 1'b1 && got_sop[at] == 1'b1, {tag, " lock+sop on last hit"},
              {got_lock[at], got_sop[at]}, 3);
        check(got_eop[at+PL-1] == 1'b1, {tag, " eop at packet end"}, got_eop[at+PL-1], 1);
        check(early == 0, {tag, " no marks while unlocked"}, early, 0);
    endtask

    task automatic t_reset;
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk); #2;
        check({out_valid, out_sop, out_eop, out_locked} == 4'b0, "R1 outputs in reset",
              {out_valid, out_sop, out_eop, out_locked}, 0);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk); #2;
        check({out_valid, out_sop, out_eop, out_locked} == 4'b0, "R1 outputs after release",
              {out_valid, out_sop, out_eop, out_locked}, 0);
    endtask

    task automatic t_parallel_lock;
        begin_run(1'b0, 1'b0);
        for (int p = 0; p < 10; p++)
            for (int o = 0; o < PL; o++) put_par(pkt_byte(p, o, 1'b1), 1'b0);
        drain();
        check_data("R2 parallel");
        check_lock_at(LOCK_AT, "R4 parallel");
        check(got_sop[LOCK_AT+PL] == 1'b1 && got_sop[LOCK_AT+1] == 1'b0,
              "R6 sop only at sync slot", {got_sop[LOCK_AT+PL], got_sop[LOCK_AT+1]}, 2);
    endtask

    task automatic t_gaps;
        begin_run(1'b0, 1'b0);
        for (int p = 0; p < 10; p++)
            for (int o = 0; o < PL; o++) put_par(pkt_byte(p, o, 1'b1), (o % 3) == 1);
        drain();
        check_data("R3 gaps");
        check_lock_at(LOCK_AT, "R3 gaps");
    endtask

    task automatic t_hunt;
        int pre;
        pre = 50;
        begin_run(1'b0, 1'b0);
        for (int i = 0; i < pre; i++) put_par((i == 0 || i == 20) ? 8'h47 : 8'h10, 1'b0);
        for (int p = 0; p < 11; p++)
            for (int o = 0; o < PL; o++) put_par(pkt_byte(p, o, 1'b1), 1'b0);
        drain();
        check_data("R5 hunt");
        check_lock_at(pre + 9 * PL, "R5 false candidate");
    endtask

    task automatic t_loss;
        int late;
        late = 0;
        begin_run(1'b0, 1'b0);
        for (int p = 0; p < 20; p++)
            for (int o = 0; o < PL; o++)
                put_par(pkt_byte(p, o, (p < 9) || (p == 10)), 1'b0);
        drain();
        check_lock_at(LOCK_AT, "R4 before loss");
        check(got_lock[9*PL] == 1'b1 && got_sop[9*PL] == 1'b1, "R7 single miss keeps lock",
              {got_lock[9*PL], got_sop[9*PL]}, 3);
        check(got_eop[9*PL+PL-1] == 1'b1, "R7 framing unchanged", got_eop[9*PL+PL-1], 1);
        check(got_lock[18*PL] == 1'b1, "R7 count cleared by good sync", got_lock[18*PL], 1);
        check(got_lock[19*PL-1] == 1'b1 && got_lock[19*PL] == 1'b0, "R8 lock lost on last miss",
              {got_lock[19*PL-1], got_lock[19*PL]}, 2);
        for (int i = 19 * PL; i < 20 * PL; i++) if (got_sop[i] || got_eop[i]) late = late + 1;
        check(late == 0, "R8 no marks after loss", late, 0);
    endtask

    task automatic t_serial;
        begin_run(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 in_valid = 1'b1; in_bit = 1'b1; in_sop = 1'b0;
        end
        for (int p = 0; p < 10; p++)
            for (int o = 0; o < PL; o++) put_ser(pkt_byte(p, o, 1'b1), o == 0);
        drain();
        check_data("R9 R10 serial");
        check_lock_at(LOCK_AT, "R9 serial");
    endtask

    task automatic t_inverted;
        begin_run(1'b0, 1'b1);
        for (int p = 0; p < 10; p++)
            for (int o = 0; o < PL; o++) put_inv(pkt_byte(p, o, 1'b1));
        drain();
        check_data("R11 falling edge");
        check_lock_at(LOCK_AT, "R11 falling edge");
    endtask

    initial begin
        t_reset();
        t_parallel_lock();
        t_gaps();
        t_hunt();
        t_loss();
        t_serial();
        t_inverted();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule